// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer with Demap

This block is a small fully associative translation buffer. Each slot holds a virtual page tag, an address-space context, a global flag, a page size (8 KB, 64 KB, 512 KB or 4 MB), a physical page number and seven attribute bits. A lookup presents a virtual address and a context. In the same cycle the block returns hit, the physical address, the page size and the attributes. The compare for each slot is masked by that slot's own page size. The low physical page bits covered by a larger page are taken straight from the virtual address.

A write port fills a chosen slot with a complete entry. A demap port removes entries in one of two ways. The page kind drops one slot whose size-masked tag matches. The context kind drops every non-global slot of a context. A bypass mode skips the table. It returns the truncated virtual address as the physical address, with a fixed attribute set that a type input selects. Slot choice on fill, table walking and fault reporting are left to the caller.

Top module: `tlb_top`

## Requirements
- R1: Reset clears every valid flag, so after reset every table lookup reports hit=0.
- R2: A write with wrReq=1 loads slot wrIdx on the next clock edge and makes it valid; a later matching lookup returns its translation.
- R3: Page size code 0=8 KB, 1=64 KB, 2=512 KB, 3=4 MB. Virtual page bits 15:13, 18:13 and 21:13 are ignored in the compare for codes 1, 2 and 3. Those same bits of the physical address are copied from the virtual address. Physical bits 12:0 always equal virtual bits 12:0.
- R4: A slot matches only when its context equals the lookup context, unless its global flag is set.
- R5: When more than one slot matches a lookup, lkMulti=1 and lkHit=1, and the output comes from the lowest-indexed matching slot.
- R6: A page demap (dmReq=1, dmKind=0) uses the rules of R3 and R4 and invalidates only the lowest-indexed matching slot; a non-matching request changes nothing.
- R7: A page demap of a large page leaves smaller-page slots that lie inside its range valid.
- R8: A context demap (dmReq=1, dmKind=1) invalidates every slot whose context equals dmCtx and whose global flag is clear; other slots stay valid.
- R9: A lookup with lkBypass=1 gives lkHit=1, lkMulti=0, lkPa equal to lkVa bits 40:0, and lkSize=0. lkAttr is packed {cp,ie,cv,e,p,w,nfo} from bit 6 down to bit 0. It is 7'h42 (cp,w) for lkBypType=0 and 7'h0A (e,w) for lkBypType=1.
- R10: In any cycle with wrReq or dmReq high, the lookup is suppressed: lkHit=0 and lkMulti=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkReq | input | 1 | Lookup request |
| lkVa | input | VA_W | Lookup virtual address |
| lkCtx | input | CTX_W | Lookup context |
| lkBypass | input | 1 | Take the bypass path instead of the table |
| lkBypType | input | 1 | Bypass attribute set: 0 plain cacheable, 1 side-effect |
| lkHit | output | 1 | Translation valid |
| lkMulti | output | 1 | More than one slot matched |
| lkPa | output | PA_W | Physical address |
| lkSize | output | 2 | Page size code of the result |
| lkAttr | output | 7 | Attribute bits {cp,ie,cv,e,p,w,nfo} |
| wrReq | input | 1 | Write request |
| wrIdx | input | log2(NUM_ENTRIES) | Slot to write |
| wrVpn | input | VA_W-13 | Virtual page tag |
| wrCtx | input | CTX_W | Context |
| wrGlobal | input | 1 | Global flag |
| wrSize | input | 2 | Page size code |
| wrPpn | input | PA_W-13 | Physical page number |
| wrAttr | input | 7 | Attribute bits |
| dmReq | input | 1 | Demap request |
| dmKind | input | 1 | 0 page demap, 1 context demap |
| dmVpn | input | VA_W-13 | Page demap tag |
| dmCtx | input | CTX_W | Demap context |

## Verification
A lookup can land in the same cycle as a write or a demap. The write or demap wins, and the lookup is reported as a miss. The bench holds lkReq high with a matching address while it presents a write. It samples lkHit before the clock edge and expects 0. A lookup after the edge must then hit the newly written slot. That shows the write was applied and the lookup was only held off.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int OFFS_W = 13;     // 8 KB base page offset
  localparam int SZMASK_W = 9;    // widest size-dependent tag span (4 MB)

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic cp;
    logic ie;
    logic cv;
    logic e;
    logic p;
    logic w;
    logic nfo;
  } pgAttr_t;

  localparam pgAttr_t BYP_PLAIN = '{cp: 1'b1, ie: 1'b0, cv: 1'b0, e: 1'b0, p: 1'b0, w: 1'b1, nfo: 1'b0};
  localparam pgAttr_t BYP_SIDE  = '{cp: 1'b0, ie: 1'b0, cv: 1'b0, e: 1'b1, p: 1'b0, w: 1'b1, nfo: 1'b0};

  typedef struct packed {
    logic doLookup;
    logic doBypass;
    logic doWrite;
    logic doDemapPage;
    logic doDemapCtx;
  } tlbStrobe_t;

  function automatic logic [SZMASK_W-1:0] sizeMask(input logic [1:0] sz);
    case (pgSize_e'(sz))
      PG_64K:  sizeMask = 9'h007;
      PG_512K: sizeMask = 9'h03F;
      PG_4M:   sizeMask = 9'h1FF;
      default: sizeMask = 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       lkReq,
  input  logic       lkBypass,
  input  logic       wrReq,
  input  logic       dmReq,
  input  logic       dmKind,
  output tlbStrobe_t strobe
);
  logic tableBusy;

  always_comb begin
    tableBusy          = wrReq | dmReq;
    strobe.doLookup    = lkReq & ~lkBypass & ~tableBusy;
    strobe.doBypass    = lkReq & lkBypass & ~tableBusy;
    strobe.doWrite     = wrReq;
    strobe.doDemapPage = dmReq & ~dmKind;
    strobe.doDemapCtx  = dmReq & dmKind;
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W = 44,
  parameter int PA_W = 41,
  parameter int CTX_W = 13,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int VPN_W = VA_W - OFFS_W,
  localparam int PPN_W = PA_W - OFFS_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobe_t             strobe,
  input  logic [VA_W-1:0]        lkVa,
  input  logic [CTX_W-1:0]       lkCtx,
  input  logic                   lkBypType,
  output logic                   lkHit,
  output logic                   lkMulti,
  output logic [PA_W-1:0]        lkPa,
  output logic [1:0]             lkSize,
  output logic [6:0]             lkAttr,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [VPN_W-1:0]       wrVpn,
  input  logic [CTX_W-1:0]       wrCtx,
  input  logic                   wrGlobal,
  input  logic [1:0]             wrSize,
  input  logic [PPN_W-1:0]       wrPpn,
  input  logic [6:0]             wrAttr,
  input  logic [VPN_W-1:0]       dmVpn,
  input  logic [CTX_W-1:0]       dmCtx,
  output logic [NUM_ENTRIES-1:0] validVec
);
  logic [NUM_ENTRIES-1:0] valid, validNext;
  logic [VPN_W-1:0] entVpn  [NUM_ENTRIES];
  logic [CTX_W-1:0] entCtx  [NUM_ENTRIES];
  logic             entGlob [NUM_ENTRIES];
  logic [1:0]       entSize [NUM_ENTRIES];
  logic [PPN_W-1:0] entPpn  [NUM_ENTRIES];
  logic [6:0]       entAttr [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lkMatch, dmPageMatch, dmCtxMatch;
  logic [VPN_W-1:0] lkVpn;
  logic [IDX_W-1:0] lkSel, dmSel;
  logic [PPN_W-1:0] passMask, mergedPpn;

  assign lkVpn = lkVa[VA_W-1:OFFS_W];

  function automatic logic [IDX_W-1:0] lowestSet(input logic [NUM_ENTRIES-1:0] vec);
    lowestSet = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--)
      if (vec[k]) lowestSet = IDX_W'(k);
  endfunction

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic [VPN_W-1:0] cmpMask;
    logic             lkCtxOk, dmCtxOk;
    assign cmpMask = ~{{(VPN_W-SZMASK_W){1'b0}}, sizeMask(entSize[i])};
    assign lkCtxOk = entGlob[i] | (entCtx[i] == lkCtx);
    assign dmCtxOk = entGlob[i] | (entCtx[i] == dmCtx);
    assign lkMatch[i]     = valid[i] & (((entVpn[i] ^ lkVpn) & cmpMask) == '0) & lkCtxOk;
    assign dmPageMatch[i] = valid[i] & (((entVpn[i] ^ dmVpn) & cmpMask) == '0) & dmCtxOk;
    assign dmCtxMatch[i]  = valid[i] & ~entGlob[i] & (entCtx[i] == dmCtx);
  end

  assign lkSel = lowestSet(lkMatch);
  assign dmSel = lowestSet(dmPageMatch);

  always_comb begin
    passMask  = {{(PPN_W-SZMASK_W){1'b0}}, sizeMask(entSize[lkSel])};
    mergedPpn = (entPpn[lkSel] & ~passMask) | (lkVa[PA_W-1:OFFS_W] & passMask);
    lkHit   = 1'b0;
    lkMulti = 1'b0;
    lkPa    = '0;
    lkSize  = 2'(PG_8K);
    lkAttr  = '0;
    if (strobe.doBypass) begin
      lkHit  = 1'b1;
      lkPa   = lkVa[PA_W-1:0];
      lkAttr = lkBypType ? BYP_SIDE : BYP_PLAIN;
    end else if (strobe.doLookup && (lkMatch != '0)) begin
      lkHit   = 1'b1;
      lkMulti = ($countones(lkMatch) > 1);
      lkPa    = {mergedPpn, lkVa[OFFS_W-1:0]};
      lkSize  = entSize[lkSel];
      lkAttr  = entAttr[lkSel];
    end
  end

  always_comb begin
    validNext = valid;
    if (strobe.doDemapPage && (dmPageMatch != '0))
      validNext[dmSel] = 1'b0;
    if (strobe.doDemapCtx)
      validNext = validNext & ~dmCtxMatch;
    if (strobe.doWrite)
      validNext[wrIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) valid <= '0;
    else       valid <= validNext;
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) begin
      entVpn[wrIdx]  <= wrVpn;
      entCtx[wrIdx]  <= wrCtx;
      entGlob[wrIdx] <= wrGlobal;
      entSize[wrIdx] <= wrSize;
      entPpn[wrIdx]  <= wrPpn;
      entAttr[wrIdx] <= wrAttr;
    end
  end

  assign validVec = valid;
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W = 44,
  parameter int PA_W = 41,
  parameter int CTX_W = 13,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int VPN_W = VA_W - OFFS_W,
  localparam int PPN_W = PA_W - OFFS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkReq,
  input  logic [VA_W-1:0]  lkVa,
  input  logic [CTX_W-1:0] lkCtx,
  input  logic             lkBypass,
  input  logic             lkBypType,
  output logic             lkHit,
  output logic             lkMulti,
  output logic [PA_W-1:0]  lkPa,
  output logic [1:0]       lkSize,
  output logic [6:0]       lkAttr,
  input  logic             wrReq,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic             wrGlobal,
  input  logic [1:0]       wrSize,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic [6:0]       wrAttr,
  input  logic             dmReq,
  input  logic             dmKind,
  input  logic [VPN_W-1:0] dmVpn,
  input  logic [CTX_W-1:0] dmCtx
);
  tlbStrobe_t             strobe;
  logic [NUM_ENTRIES-1:0] validVec;

  tlb_ctrl u_ctrl (
    .lkReq(lkReq), .lkBypass(lkBypass), .wrReq(wrReq),
    .dmReq(dmReq), .dmKind(dmKind), .strobe(strobe)
  );

  tlb_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkVa(lkVa), .lkCtx(lkCtx), .lkBypType(lkBypType),
    .lkHit(lkHit), .lkMulti(lkMulti), .lkPa(lkPa), .lkSize(lkSize), .lkAttr(lkAttr),
    .wrIdx(wrIdx), .wrVpn(wrVpn), .wrCtx(wrCtx), .wrGlobal(wrGlobal),
    .wrSize(wrSize), .wrPpn(wrPpn), .wrAttr(wrAttr),
    .dmVpn(dmVpn), .dmCtx(dmCtx), .validVec(validVec)
  );
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int PA_W = 41,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   lkReq,
  input logic                   lkBypass,
  input logic                   lkBypType,
  input logic [PA_W-1:0]        lkVaLow,
  input logic                   wrReq,
  input logic [IDX_W-1:0]       wrIdx,
  input logic                   dmReq,
  input logic                   lkHit,
  input logic                   lkMulti,
  input logic [PA_W-1:0]        lkPa,
  input logic [1:0]             lkSize,
  input logic [6:0]             lkAttr,
  input logic [NUM_ENTRIES-1:0] validVec
);
  logic bypassNow;
  assign bypassNow = lkReq & lkBypass & ~wrReq & ~dmReq;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (validVec == '0)); // R1

  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> validVec[$past(wrIdx)]); // R2

  AST_MULTI_HIT: assert property (@(posedge clk) disable iff (!rstN)
    lkMulti |-> lkHit); // R5

  AST_DEMAP_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (dmReq && !wrReq) |=> ($countones(validVec) <= $countones($past(validVec)))); // R8

  AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    bypassNow |-> (lkHit && !lkMulti && lkPa == lkVaLow && lkSize == 2'd0)); // R9

  AST_BYPASS_ATTR: assert property (@(posedge clk) disable iff (!rstN)
    bypassNow |-> (lkAttr == (lkBypType ? 7'h0A : 7'h42))); // R9

  AST_BUSY_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq || dmReq) |-> (!lkHit && !lkMulti)); // R10
endmodule

bind tlb_top tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkReq(lkReq), .lkBypass(lkBypass), .lkBypType(lkBypType),
  .lkVaLow(lkVa[PA_W-1:0]), .wrReq(wrReq), .wrIdx(wrIdx), .dmReq(dmReq),
  .lkHit(lkHit), .lkMulti(lkMulti), .lkPa(lkPa), .lkSize(lkSize), .lkAttr(lkAttr),
  .validVec(validVec)
);

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkReq = 0, lkBypass = 0, lkBypType = 0;
  logic [43:0] lkVa = '0;
  logic [12:0] lkCtx = '0;
  logic lkHit, lkMulti;
  logic [40:0] lkPa;
  logic [1:0] lkSize;
  logic [6:0] lkAttr;
  logic wrReq = 0, wrGlobal = 0;
  logic [2:0] wrIdx = '0;
  logic [30:0] wrVpn = '0;
  logic [12:0] wrCtx = '0;
  logic [1:0] wrSize = '0;
  logic [27:0] wrPpn = '0;
  logic [6:0] wrAttr = '0;
  logic dmReq = 0, dmKind = 0;
  logic [30:0] dmVpn = '0;
  logic [12:0] dmCtx = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_top dut (
    .clk(clk), .rstN(rstN), .lkReq(lkReq), .lkVa(lkVa), .lkCtx(lkCtx),
    .lkBypass(lkBypass), .lkBypType(lkBypType), .lkHit(lkHit), .lkMulti(lkMulti),
    .lkPa(lkPa), .lkSize(lkSize), .lkAttr(lkAttr), .wrReq(wrReq), .wrIdx(wrIdx),
    .wrVpn(wrVpn), .wrCtx(wrCtx), .wrGlobal(wrGlobal), .wrSize(wrSize),
    .wrPpn(wrPpn), .wrAttr(wrAttr), .dmReq(dmReq), .dmKind(dmKind),
    .dmVpn(dmVpn), .dmCtx(dmCtx)
  );

  typedef struct packed {
    logic [43:0] va;
    logic [12:0] ctx;
    logic        byp;
    logic        bt;
    logic        hit;
    logic        multi;
    logic [40:0] pa;
    logic [1:0]  size;
    logic [6:0]  attr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{44'h000_0040_0123, 13'd5, 1'b0, 1'b0, 1'b1, 1'b0, 41'h0_0020_0123, 2'd0, 7'h42}, // R2 8K
    '{44'h000_0040_0123, 13'd6, 1'b0, 1'b0, 1'b0, 1'b0, 41'h0, 2'd0, 7'h00},           // R4 ctx miss
    '{44'h000_0100_E456, 13'd5, 1'b0, 1'b0, 1'b1, 1'b0, 41'h0_0040_E456, 2'd1, 7'h43}, // R3 64K
    '{44'h000_8012_3456, 13'd3, 1'b0, 1'b0, 1'b1, 1'b0, 41'h0_0212_3456, 2'd3, 7'h50}, // R4 global
    '{44'h000_8020_0010, 13'd7, 1'b0, 1'b0, 1'b1, 1'b1, 41'h0_0220_0010, 2'd3, 7'h50}, // R5 multi
    '{44'h000_0400_7FFF, 13'd9, 1'b0, 1'b0, 1'b1, 1'b0, 41'h0_0080_7FFF, 2'd2, 7'h46}, // R3 512K
    '{44'h000_0400_7FFF, 13'd5, 1'b0, 1'b0, 1'b0, 1'b0, 41'h0, 2'd0, 7'h00},           // R4
    '{44'h000_0408_0000, 13'd9, 1'b0, 1'b0, 1'b0, 1'b0, 41'h0, 2'd0, 7'h00},           // R3 outside
    '{44'h800_0040_0123, 13'd5, 1'b0, 1'b0, 1'b0, 1'b0, 41'h0, 2'd0, 7'h00},           // R3 high bit
    '{44'hABC_DEF0_1234, 13'd0, 1'b1, 1'b0, 1'b1, 1'b0, 41'h0BC_DEF0_1234, 2'd0, 7'h42}, // R9 plain
    '{44'hABC_DEF0_1234, 13'd0, 1'b1, 1'b1, 1'b1, 1'b0, 41'h0BC_DEF0_1234, 2'd0, 7'h0A}, // R9 side
    '{44'h000_0101_0000, 13'd5, 1'b0, 1'b0, 1'b0, 1'b0, 41'h0, 2'd0, 7'h00}            // R3 next page
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lkReq = 0; lkBypass = 0; wrReq = 0; dmReq = 0;
  endtask

  task automatic doWrite(input logic [2:0] idx, input logic [43:0] va, input logic [12:0] ctx,
                         input logic g, input logic [1:0] sz, input logic [27:0] ppn,
                         input logic [6:0] at, input logic keepLook);
    @(negedge clk);
    if (!keepLook) idle();
    wrReq = 1; wrIdx = idx; wrVpn = va[43:13]; wrCtx = ctx; wrGlobal = g;
    wrSize = sz; wrPpn = ppn; wrAttr = at;
  endtask

  task automatic doDemap(input logic kind, input logic [43:0] va, input logic [12:0] ctx);
    @(negedge clk);
    idle();
    dmReq = 1; dmKind = kind; dmVpn = va[43:13]; dmCtx = ctx;
    @(negedge clk);
    dmReq = 0;
  endtask

  task automatic look(input logic [43:0] va, input logic [12:0] ctx, input logic byp, input logic bt);
    @(negedge clk);
    idle();
    lkReq = 1; lkVa = va; lkCtx = ctx; lkBypass = byp; lkBypType = bt;
    #2;
  endtask

  task automatic expectHit(input string req, input logic [40:0] pa, input logic multi);
    chk({req, " hit"}, 64'(lkHit), 64'd1);
    chk({req, " multi"}, 64'(lkMulti), 64'(multi));
    chk({req, " pa"}, 64'(lkPa), 64'(pa));
  endtask

  task automatic expectMiss(input string req);
    chk({req, " hit"}, 64'(lkHit), 64'd0);
    chk({req, " multi"}, 64'(lkMulti), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    look(44'h000_0040_0123, 13'd5, 0, 0);
    expectMiss("R1 after reset");

    doWrite(3'd0, 44'h000_0040_0000, 13'd5, 0, 2'd0, 28'h100, 7'h42, 0);
    doWrite(3'd1, 44'h000_0100_0000, 13'd5, 0, 2'd1, 28'h200, 7'h43, 0);
    doWrite(3'd2, 44'h000_8000_0000, 13'd7, 1, 2'd3, 28'h1000, 7'h50, 0);
    doWrite(3'd3, 44'h000_0400_0000, 13'd9, 0, 2'd2, 28'h400, 7'h46, 0);
    doWrite(3'd4, 44'h000_8020_0000, 13'd7, 0, 2'd0, 28'h55, 7'h0A, 0);

    for (int v = 0; v < NVEC; v++) begin
      look(VECS[v].va, VECS[v].ctx, VECS[v].byp, VECS[v].bt);
      chk($sformatf("R2 R3 R4 R5 R9 vec%0d hit", v), 64'(lkHit), 64'(VECS[v].hit));
      chk($sformatf("R5 vec%0d multi", v), 64'(lkMulti), 64'(VECS[v].multi));
      if (VECS[v].hit) begin
        chk($sformatf("R3 R9 vec%0d pa", v), 64'(lkPa), 64'(VECS[v].pa));
        chk($sformatf("R3 R9 vec%0d size", v), 64'(lkSize), 64'(VECS[v].size));
        chk($sformatf("R9 vec%0d attr", v), 64'(lkAttr), 64'(VECS[v].attr));
      end
    end

    // R10: lookup held high during a write
    look(44'h000_0070_0000, 13'd1, 0, 0);
    doWrite(3'd7, 44'h000_0070_0000, 13'd1, 0, 2'd0, 28'h9, 7'h42, 1);
    #2;
    expectMiss("R10 lookup with write");
    look(44'h000_0040_0123, 13'd5, 0, 0);
    @(negedge clk);
    idle();
    dmReq = 1; dmKind = 1; dmCtx = 13'd100; lkReq = 1;
    #2;
    expectMiss("R10 lookup with demap");
    look(44'h000_0070_0000, 13'd1, 0, 0);
    expectHit("R2 after write", 41'h12000, 0);

    // R6: context mismatch leaves a non-global slot alone
    doDemap(0, 44'h000_0040_0000, 13'd6);
    look(44'h000_0040_0123, 13'd5, 0, 0);
    expectHit("R6 ctx mismatch kept", 41'h20_0123, 0);

    // R6 R7: demap 4M global page, inner 8K page survives
    doDemap(0, 44'h000_8000_0000, 13'd3);
    look(44'h000_8012_3456, 13'd3, 0, 0);
    expectMiss("R6 4M removed");
    look(44'h000_8020_0010, 13'd7, 0, 0);
    expectHit("R7 inner 8K kept", 41'hAA010, 0);

    // R5 R6: duplicate slots, demap removes only the lowest
    doWrite(3'd5, 44'h000_0040_0000, 13'd5, 0, 2'd0, 28'h111, 7'h42, 0);
    look(44'h000_0040_0123, 13'd5, 0, 0);
    expectHit("R5 duplicate lowest", 41'h20_0123, 1);
    doDemap(0, 44'h000_0040_0000, 13'd5);
    look(44'h000_0040_0123, 13'd5, 0, 0);
    expectHit("R6 single removed", 41'h22_2123, 0);

    // R3 R6: demap 64K page with offset bits inside the page
    doDemap(0, 44'h000_0100_E000, 13'd5);
    look(44'h000_0100_E456, 13'd5, 0, 0);
    expectMiss("R6 64K masked demap");

    // R8: context demap keeps global and other contexts
    doWrite(3'd6, 44'h000_0060_0000, 13'd5, 1, 2'd0, 28'h77, 7'h42, 0);
    doDemap(1, 44'h0, 13'd5);
    look(44'h000_0040_0123, 13'd5, 0, 0);
    expectMiss("R8 ctx removed");
    look(44'h000_0060_0010, 13'd5, 0, 0);
    expectHit("R8 global kept", 41'hEE010, 0);
    look(44'h000_0400_7FFF, 13'd9, 0, 0);
    expectHit("R8 other ctx kept", 41'h80_7FFF, 0);

    // R1: reset in mid-run empties the table
    @(negedge clk);
    idle();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    look(44'h000_0400_7FFF, 13'd9, 0, 0);
    expectMiss("R1 mid-run reset");
    look(44'h000_0060_0010, 13'd5, 0, 0);
    expectMiss("R1 global cleared");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule